// File: doc/BRIEF.md
# Signed-Digit to Binary Borrow-Lookahead Converter

This block takes a redundant radix-r number, with r = 2^M, and produces its ordinary unsigned binary value. The number has Q low digits and one extra top bit. Each low digit takes values from -1 to r-1 and arrives as a sign flag plus an M-bit magnitude. Its value is the magnitude minus the sign flag. The top bit has weight r^Q. The block typically sits at the output of a carry-free redundant adder, where the final conversion to binary is the only step whose depth grows with word length.

Each low digit becomes a canonical digit in 0..r-1. This is done by subtracting the digit's own sign flag and the borrow that arrives from the digit below it. The borrows are resolved by a generate/propagate lookahead. With the default parallel-prefix variant the lookahead has log2(Q) levels. A cheaper serial variant can be selected by parameter. The binary word is the concatenation of the canonical digits, topped by one bit formed from the top input bit and the final borrow. A value below zero cannot be produced by a correct upstream adder, but if one arrives it raises a flag.

Top module: `sdc_to_bin`

## Requirements
- R1: Low digit j is carried on `dig_sign[j]` and `dig_mag[j*M +: M]`, and its value is magnitude minus sign. Every combination is accepted, including a set sign flag with a non-zero magnitude.
- R2: When the total value V = top_bit·r^Q + Σ (mag_j − sign_j)·r^j is zero or more, `bin_out` equals V and `neg_flag` is 0.
- R3: When every sign flag is 0, `bin_out` equals `{top_bit, dig_mag}` unchanged.
- R4: A borrow arriving at a digit whose magnitude is 2 or more is absorbed there and does not reach the digit above.
- R5: A digit with its sign flag set and magnitude 0 creates a borrow. A run of such digits passes a borrow all the way to the top, so all digits at -1 with top_bit 1 gives the value r^Q − (r^Q−1)/(r−1).
- R6: The most significant output bit is 1 exactly when top_bit is 1 and no borrow leaves the highest low digit.
- R7: When V is below zero, `neg_flag` is 1, the output MSB is 0, and the low M·Q bits hold V + r^Q.
- R8: The parallel-prefix lookahead (LA_STYLE 0) and the serial chain (LA_STYLE 1) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dig_sign | input | Q | Sign flag of each low digit, weight −1 |
| dig_mag | input | M·Q | Magnitude of each low digit, digit j in bits j·M+M−1..j·M |
| top_bit | input | 1 | Top digit, weight r^Q |
| bin_out | output | M·Q+1 | Unsigned binary result |
| neg_flag | output | 1 | Input value was below zero |

## Verification
The inputs that carry no sign flag show whether the magnitudes pass through untouched. Vectors of all −1 digits, with the top bit both set and clear, stretch the borrow across every position and separate the prefix tree from a wrong span or a missing level. The alternating −1 / r−1 pattern checks that the borrow stops at large magnitudes. Random legal digit vectors and random unrestricted sign/magnitude pairs are compared against an integer sum of digit values, which covers the two-borrow corner cases (magnitude 0 or 1 with both borrow-in and sign). The negative-value flag is checked on the same data for both lookahead variants.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   // lookahead variant selector
   localparam int LA_PREFIX = 0;
   localparam int LA_SERIAL = 1;

   // per-digit borrow terms
   typedef struct packed {
      logic gen;
      logic prop;
   } bgp_t;
endpackage

// File: rtl/sdc_digit_cell.sv
module sdc_digit_cell #(
   parameter int M = 2
) (
   input  logic         sign_i,
   input  logic [M-1:0] mag_i,
   input  logic         bin_i,
   output sdc_pkg::bgp_t gp_o,
   output logic [M-1:0] dig_o
);
   localparam logic [M-1:0] ONE_M = M'(1);

   logic mag_zero;
   logic mag_one;

   assign mag_zero = (mag_i == '0);
   assign mag_one  = (mag_i == ONE_M);

   // borrow created here: a sign flag with nothing to take it from
   assign gp_o.gen  = sign_i & mag_zero;
   // borrow passed through: nothing left after an incoming borrow
   assign gp_o.prop = mag_zero | (sign_i & mag_one);

   // canonical digit, wraps modulo r
   assign dig_o = mag_i - M'(sign_i) - M'(bin_i);
endmodule

// File: rtl/sdc_borrow_tree.sv
module sdc_borrow_tree #(
   parameter int Q        = 8,
   parameter int LA_STYLE = sdc_pkg::LA_PREFIX
) (
   input  logic [Q-1:0] gen_i,
   input  logic [Q-1:0] prop_i,
   output logic [Q-1:0] borrow_o
);
   localparam int LVLS = (Q > 1) ? $clog2(Q) : 0;

   if (LA_STYLE == sdc_pkg::LA_PREFIX) begin : g_prefix
      logic [Q-1:0] gs [0:LVLS];
      logic [Q-1:0] ps [0:LVLS];

      assign gs[0] = gen_i;
      assign ps[0] = prop_i;

      for (genvar s = 0; s < LVLS; s++) begin : g_lvl
         localparam int SPAN = 1 << s;
         for (genvar i = 0; i < Q; i++) begin : g_node
            if (i >= SPAN) begin : g_join
               assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-SPAN]);
               assign ps[s+1][i] = ps[s][i] & ps[s][i-SPAN];
            end else begin : g_pass
               assign gs[s+1][i] = gs[s][i];
               assign ps[s+1][i] = ps[s][i];
            end
         end
      end

      assign borrow_o = gs[LVLS];
   end else begin : g_serial
      for (genvar i = 0; i < Q; i++) begin : g_step
         if (i == 0) begin : g_first
            assign borrow_o[i] = gen_i[i];
         end else begin : g_next
            assign borrow_o[i] = gen_i[i] | (prop_i[i] & borrow_o[i-1]);
         end
      end
   end
endmodule

// File: rtl/sdc_to_bin.sv
module sdc_to_bin #(
   parameter int M        = 2,
   parameter int Q        = 8,
   parameter int LA_STYLE = sdc_pkg::LA_PREFIX
) (
   input  logic [Q-1:0]   dig_sign,
   input  logic [M*Q-1:0] dig_mag,
   input  logic           top_bit,
   output logic [M*Q:0]   bin_out,
   output logic           neg_flag
);
   localparam int LOW_W = M * Q;

   if (M < 1) begin : g_bad_m
      $error("sdc_to_bin: M must be at least 1");
   end
   if (Q < 1) begin : g_bad_q
      $error("sdc_to_bin: Q must be at least 1");
   end
   if (LA_STYLE != sdc_pkg::LA_PREFIX && LA_STYLE != sdc_pkg::LA_SERIAL) begin : g_bad_style
      $error("sdc_to_bin: unknown LA_STYLE");
   end

   logic [Q-1:0]     la_gen;
   logic [Q-1:0]     la_prop;
   logic [Q-1:0]     la_borrow;
   logic [Q-1:0]     bin_in;
   logic [LOW_W-1:0] canon;

   for (genvar j = 0; j < Q; j++) begin : g_dig
      sdc_pkg::bgp_t gp;

      if (j == 0) begin : g_lsd
         assign bin_in[j] = 1'b0;
      end else begin : g_upper
         assign bin_in[j] = la_borrow[j-1];
      end

      sdc_digit_cell #(.M(M)) u_cell (
         .sign_i (dig_sign[j]),
         .mag_i  (dig_mag[j*M +: M]),
         .bin_i  (bin_in[j]),
         .gp_o   (gp),
         .dig_o  (canon[j*M +: M])
      );

      assign la_gen[j]  = gp.gen;
      assign la_prop[j] = gp.prop;
   end

   sdc_borrow_tree #(.Q(Q), .LA_STYLE(LA_STYLE)) u_tree (
      .gen_i    (la_gen),
      .prop_i   (la_prop),
      .borrow_o (la_borrow)
   );

   assign bin_out  = {top_bit & ~la_borrow[Q-1], canon};
   assign neg_flag = la_borrow[Q-1] & ~top_bit;
endmodule

// File: rtl/sdc_to_bin_chk.sv
module sdc_to_bin_chk #(
   parameter int M = 2,
   parameter int Q = 8
) (
   input logic [Q-1:0]   dig_sign,
   input logic [M*Q-1:0] dig_mag,
   input logic           top_bit,
   input logic [M*Q:0]   bin_out,
   input logic           neg_flag,
   input logic [Q-1:0]   la_gen,
   input logic [Q-1:0]   la_prop,
   input logic [Q-1:0]   la_borrow
);
   always_comb begin
      AST_CLEAN_PASS: assert (dig_sign != '0 || (bin_out == {top_bit, dig_mag} && !neg_flag))
         else $error("clean input altered"); // R3
      AST_FLAG_EXCL: assert (!(neg_flag && (bin_out[M*Q] || top_bit)))
         else $error("negative flag with top bit"); // R7
      for (int j = 0; j < Q; j++) begin
         logic prev;
         prev = (j == 0) ? 1'b0 : la_borrow[(j == 0) ? 0 : j-1];
         AST_BORROW_CHAIN: assert (la_borrow[j] == (la_gen[j] | (la_prop[j] & prev)))
            else $error("lookahead mismatch at %0d", j); // R8
         AST_HIGH_ABSORB: assert (dig_mag[j*M +: M] < 2 || !la_borrow[j])
            else $error("borrow escaped large digit %0d", j); // R4
         AST_ZERO_GEN: assert (!(dig_sign[j] && dig_mag[j*M +: M] == '0) || la_borrow[j])
            else $error("missing borrow at %0d", j); // R5
      end
   end
endmodule

bind sdc_to_bin sdc_to_bin_chk #(.M(M), .Q(Q)) u_chk (
   .dig_sign  (dig_sign),
   .dig_mag   (dig_mag),
   .top_bit   (top_bit),
   .bin_out   (bin_out),
   .neg_flag  (neg_flag),
   .la_gen    (la_gen),
   .la_prop   (la_prop),
   .la_borrow (la_borrow)
);

// File: tb/tb_sdc_to_bin.sv
module tb_sdc_to_bin;
   localparam int M  = 2;
   localparam int Q  = 8;
   localparam int LW = M * Q;
   localparam int OW = LW + 1;
   localparam int R  = 1 << M;

   typedef struct {
      logic [OW-1:0] out;
      logic          neg;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [Q-1:0]  s_in = '0;
   logic [LW-1:0] v_in = '0;
   logic          t_in = 1'b0;
   logic [OW-1:0] out_p, out_s;
   logic          neg_p, neg_s;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t sb_q[$];

   sdc_to_bin #(.M(M), .Q(Q), .LA_STYLE(0)) dut (
      .dig_sign(s_in), .dig_mag(v_in), .top_bit(t_in),
      .bin_out(out_p), .neg_flag(neg_p));

   sdc_to_bin #(.M(M), .Q(Q), .LA_STYLE(1)) dut_ser (
      .dig_sign(s_in), .dig_mag(v_in), .top_bit(t_in),
      .bin_out(out_s), .neg_flag(neg_s));

   // reference from the digit values as integers
   task automatic drive(input logic [Q-1:0] s, input logic [LW-1:0] v,
                        input logic t, input string tag);
      longint val;
      exp_t   e;
      val = t ? (longint'(1) << LW) : 0;
      for (int j = 0; j < Q; j++)
         val += (longint'(v[j*M +: M]) - longint'(s[j])) * (longint'(1) << (M*j));
      if (val < 0) begin
         e.neg = 1'b1;
         e.out = OW'(val + (longint'(1) << LW));
      end else begin
         e.neg = 1'b0;
         e.out = OW'(val);
      end
      e.tag = tag;
      @(posedge clk);
      #1;
      s_in = s; v_in = v; t_in = t;
      sb_q.push_back(e);
   endtask

   // monitor: one pop per cycle, sampled at the falling edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (out_p !== e.out || neg_p !== e.neg) begin
               fails++;
               $display("FAIL %s prefix: got %h/%b expected %h/%b", e.tag, out_p, neg_p, e.out, e.neg);
            end
            checks++;
            if (out_s !== out_p || neg_s !== neg_p) begin
               fails++;
               $display("FAIL R8 serial vs prefix (%s): got %h/%b expected %h/%b", e.tag, out_s, neg_s, out_p, neg_p);
            end
         end
      end
   end

   function automatic logic [LW-1:0] fill_mag(input int val);
      logic [LW-1:0] r;
      for (int j = 0; j < Q; j++) r[j*M +: M] = M'(val);
      return r;
   endfunction

   initial begin
      logic [Q-1:0]  s;
      logic [LW-1:0] v;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // idle inputs: zero result
      drive('0, '0, 1'b0, "R2 zero");
      // sign-free inputs pass through
      drive('0, fill_mag(R-1), 1'b1, "R3 all max");
      drive('0, LW'(16'hA5C3), 1'b0, "R3 pattern");
      // 1*r^Q with zero digits
      drive('0, '0, 1'b1, "R6 top only");
      // all digits -1
      drive('1, '0, 1'b1, "R5 all minus one top set");
      drive('1, '0, 1'b0, "R7 all minus one negative");
      // borrow chain stopped by a large digit
      s = '1; v = '0; s[Q-1] = 1'b0; v[(Q-1)*M +: M] = M'(2);
      drive(s, v, 1'b0, "R4 chain stops at 2");
      // alternating -1 and r-1
      s = '0; v = '0;
      for (int j = 0; j < Q; j += 2) s[j] = 1'b1;
      for (int j = 1; j < Q; j += 2) v[j*M +: M] = M'(R-1);
      drive(s, v, 1'b0, "R4 alternating");
      drive(s, v, 1'b1, "R6 alternating top");
      // sign with magnitude 1: value 0, passes borrow
      drive('1, fill_mag(1), 1'b0, "R1 sign and one");
      s = '0; s[0] = 1'b1;
      drive(s, fill_mag(1), 1'b0, "R1 low borrow through ones");
      // lowest digit -1, top set: borrow reaches the top bit
      drive(1, '0, 1'b1, "R6 top consumed");
      // random legal digits
      for (int k = 0; k < 300; k++) begin
         for (int j = 0; j < Q; j++) begin
            if (($urandom % 4) == 0) begin
               s[j] = 1'b1; v[j*M +: M] = '0;
            end else begin
               s[j] = 1'b0; v[j*M +: M] = M'($urandom);
            end
         end
         drive(s, v, 1'($urandom), "R2 random legal");
      end
      // random unrestricted pairs
      for (int k = 0; k < 300; k++)
         drive(Q'($urandom), LW'($urandom), 1'($urandom), "R1 random pairs");

      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule